// File: doc/BRIEF.md
# Receive Character Buffer with Early Stop Request

This block sits between the byte output of a serial receiver and a CPU bus. Each received character arrives as a one-cycle strobe with its byte. The block stores it in a 16-entry first-in first-out buffer. The CPU drains the buffer through a small register window, and an interrupt tells service software that characters are waiting to be moved into a larger memory buffer.

Flow control is driven actively toward the sending host through an RTS/CTS-style stop request. The request rises while four entries are still free, so a sender that keeps going for up to three characters after being told to pause still finds room. The request falls again once the CPU has drained the buffer to half full. The gap between the two levels avoids toggling the line on every character. A character is refused only when every entry is occupied. Such a loss is recorded in a sticky overrun flag and is never silent.

At 115200 baud a character arrives roughly every 87 µs. The block accepts one character per clock and can store and hand out a character in the same cycle, so it keeps pace with any bus clock.

Top module: `rx_flow_fifo`

## Requirements
- R1: After synchronous reset the buffer is empty, `stop_req` and `irq` are low, the overrun flag and the interrupt enable are clear, and `bus_rdata` is 0.
- R2: A read strobe at address 0 loads the oldest stored byte onto `bus_rdata` at the next clock edge and removes that byte. Bytes come out in arrival order.
- R3: The buffer holds 16 bytes. With no reads, sixteen strobes are all retained and read back in order.
- R4: `stop_req` goes high at the clock edge that brings the occupancy to 12 (four entries free). It stays high while the occupancy is 12 or more.
- R5: Once high, `stop_req` stays high until the occupancy falls to 8 or fewer. It goes low at the edge that reaches 8.
- R6: A sender that stops no later than three characters after it sees `stop_req` high loses no character and never causes overrun, even when the CPU reads more slowly than the sender sends.
- R7: A strobe that arrives while 16 bytes are held, with no data read in the same cycle, is dropped and sets the overrun flag. If a data read happens in the same cycle, the strobe is accepted.
- R8: A read at address 1 returns status with bit 0 = data available, bit 1 = `stop_req`, bit 2 = overrun and other bits 0. The returned value shows overrun as it was before the read, and the read then clears it. A drop in that same cycle leaves overrun set.
- R9: A data read while the buffer is empty returns the byte most recently removed (0 after reset) and changes neither the stored contents nor the occupancy.
- R10: A write at address 2 sets the receive interrupt enable from `bus_wdata` bit 0. A read at address 2 returns the enable in bit 0. `irq` is high exactly while the enable is set and the buffer is not empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe: a received byte is present |
| rx_data | input | 8 | Received byte |
| bus_rd | input | 1 | CPU read strobe |
| bus_wr | input | 1 | CPU write strobe |
| bus_addr | input | 2 | Register select: 0 data, 1 status, 2 control |
| bus_wdata | input | 8 | CPU write data |
| bus_rdata | output | 8 | Read result, valid from the clock edge after the read strobe |
| stop_req | output | 1 | High asks the sender to pause |
| irq | output | 1 | Receive interrupt |

## Verification
The bench targets the two flow-control thresholds one byte at a time. A design that raised the stop request only when full would let the late characters overrun. A design without hysteresis would drop the request at 11 rather than 8. A full buffer is exercised both with a lone strobe, which must be dropped and flagged, and with a strobe that arrives alongside a data read, which a careless full test would wrongly refuse. Status read-to-clear, empty-buffer reads that must return the previous byte without moving pointers, and a long paced transfer from a sender that overshoots by three characters complete the set. Each of these would show up as a wrong byte, a missing byte or a spurious overrun.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_STAT = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [4:0] spare;
        logic       overrun;
        logic       stopping;
        logic       avail;
    } stat_t;

    function automatic stat_t make_status(input logic ovr, input logic stp, input logic av);
        stat_t s;
        s.spare    = '0;
        s.overrun  = ovr;
        s.stopping = stp;
        s.avail    = av;
        return s;
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_req,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop_req,
    output logic [DATA_W-1:0] head_data,
    output logic [LVL_W-1:0]  level,
    output logic [LVL_W-1:0]  level_nxt,
    output logic              empty,
    output logic              dropped
);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [LVL_W-1:0] lvl_q;
    logic             do_pop, do_push;
    logic [DEPTH-1:0][DATA_W-1:0] cells;

    assign do_pop  = pop_req && (lvl_q != '0);
    assign do_push = push_req && ((lvl_q != FULL_LVL) || do_pop);
    assign dropped = push_req && !do_push;

    always_comb begin
        case ({do_push, do_pop})
            2'b10:   level_nxt = lvl_q + 1'b1;
            2'b01:   level_nxt = lvl_q - 1'b1;
            default: level_nxt = lvl_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            lvl_q  <= '0;
        end else begin
            lvl_q <= level_nxt;
            if (do_push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
        end
    end

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cell
        logic [DATA_W-1:0] cell_q;
        always_ff @(posedge clk) begin
            if (do_push && (wr_ptr == PTR_W'(gi))) cell_q <= push_data;
        end
        assign cells[gi] = cell_q;
    end

    assign head_data = cells[rd_ptr];
    assign level     = lvl_q;
    assign empty     = (lvl_q == '0);
endmodule

// File: rtl/rxq_flow.sv
module rxq_flow #(
    parameter int LVL_W = 5,
    parameter int HI    = 12,
    parameter int LO    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] level_nxt,
    output logic             stop
);
    localparam logic [LVL_W-1:0] HI_L = LVL_W'(HI);
    localparam logic [LVL_W-1:0] LO_L = LVL_W'(LO);

    logic stop_q;

    always_ff @(posedge clk) begin
        if (rst)                    stop_q <= 1'b0;
        else if (level_nxt >= HI_L) stop_q <= 1'b1;
        else if (level_nxt <= LO_L) stop_q <= 1'b0;
    end

    assign stop = stop_q;
endmodule

// File: rtl/rxq_regs.sv
module rxq_regs
    import rxq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] head_data,
    input  logic              empty,
    input  logic              stop,
    input  logic              dropped,
    output logic              pop_req,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              overrun
);
    reg_sel_e          sel;
    stat_t             stat_now;
    logic [DATA_W-1:0] rdata_q, last_q;
    logic              ovr_q, ie_q;

    assign sel      = reg_sel_e'(bus_addr);
    assign pop_req  = bus_rd && (sel == SEL_DATA) && !empty;
    assign stat_now = make_status(ovr_q, stop, !empty);

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
            last_q  <= '0;
            ovr_q   <= 1'b0;
            ie_q    <= 1'b0;
        end else begin
            if (bus_rd) begin
                case (sel)
                    SEL_DATA: begin
                        if (!empty) begin
                            rdata_q <= head_data;
                            last_q  <= head_data;
                        end else begin
                            rdata_q <= last_q;
                        end
                    end
                    SEL_STAT: rdata_q <= DATA_W'(stat_now);
                    SEL_CTRL: rdata_q <= DATA_W'(ie_q);
                    default:  rdata_q <= '0;
                endcase
            end
            if (dropped)                           ovr_q <= 1'b1;
            else if (bus_rd && (sel == SEL_STAT))  ovr_q <= 1'b0;
            if (bus_wr && (sel == SEL_CTRL))       ie_q  <= bus_wdata[0];
        end
    end

    assign bus_rdata = rdata_q;
    assign irq       = ie_q && !empty;
    assign overrun   = ovr_q;
endmodule

// File: rtl/rx_flow_fifo.sv
module rx_flow_fifo #(
    parameter int DATA_W       = 8,
    parameter int DEPTH        = 16,
    parameter int LATE_CHARS   = 3,
    parameter int RESUME_LEVEL = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              stop_req,
    output logic              irq
);
    localparam int LVL_W   = $clog2(DEPTH + 1);
    localparam int HI_MARK = DEPTH - (LATE_CHARS + 1);

    logic [DATA_W-1:0] head;
    logic [LVL_W-1:0]  lvl, lvl_nxt;
    logic              empty, dropped, pop, stop, ovr;

    rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst),
        .push_req(rx_valid), .push_data(rx_data), .pop_req(pop),
        .head_data(head), .level(lvl), .level_nxt(lvl_nxt),
        .empty(empty), .dropped(dropped)
    );

    rxq_flow #(.LVL_W(LVL_W), .HI(HI_MARK), .LO(RESUME_LEVEL)) u_flow (
        .clk(clk), .rst(rst), .level_nxt(lvl_nxt), .stop(stop)
    );

    rxq_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst(rst),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .head_data(head), .empty(empty), .stop(stop), .dropped(dropped),
        .pop_req(pop), .bus_rdata(bus_rdata), .irq(irq), .overrun(ovr)
    );

    assign stop_req = stop;
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
    parameter int LVL_W = 5,
    parameter int DEPTH = 16,
    parameter int HI    = 12,
    parameter int LO    = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             rx_valid,
    input logic             bus_rd,
    input logic [1:0]       bus_addr,
    input logic             stop_req,
    input logic             irq,
    input logic [LVL_W-1:0] level,
    input logic             overrun
);
    assert_stop_high_R4: assert property (@(posedge clk) disable iff (rst)
        (level >= LVL_W'(HI)) |-> stop_req);

    assert_stop_rise_on_byte_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(stop_req) |-> $past(rx_valid));

    assert_stop_low_R5: assert property (@(posedge clk) disable iff (rst)
        (level <= LVL_W'(LO)) |-> !stop_req);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        level <= LVL_W'(DEPTH));

    assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (overrun && !(bus_rd && bus_addr == 2'd1)) |=> overrun);

    assert_empty_read_still_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 2'd0 && level == '0 && !rx_valid) |=> (level == '0));

    assert_irq_needs_data_R10: assert property (@(posedge clk) disable iff (rst)
        irq |-> (level != '0));
endmodule

bind rx_flow_fifo rxq_checker #(
    .LVL_W(LVL_W), .DEPTH(DEPTH), .HI(HI_MARK), .LO(RESUME_LEVEL)
) u_chk (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .stop_req(stop_req), .irq(irq), .level(lvl), .overrun(ovr)
);

// File: tb/test_rx_flow_fifo.sv
module test_rx_flow_fifo;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int HI         = 12;
    localparam int LO         = 8;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       stop_req, irq;

    rx_flow_fifo i_rx_flow_fifo (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .stop_req(stop_req), .irq(irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_chk = 0, n_fail = 0, cycles = 0, popped = 0;
    bit done = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("[TB] FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model
    logic [7:0] q[$];
    logic [7:0] m_last = '0, m_rdata = '0;
    bit m_ov = 0, m_ie = 0, m_stop = 0;

    always @(posedge clk) begin
        if (rst) begin
            q.delete();
            m_last = '0; m_rdata = '0; m_ov = 0; m_ie = 0; m_stop = 0;
        end else begin
            bit drop;
            drop = 0;
            if (bus_rd) begin
                case (bus_addr)
                    2'd0: m_rdata = (q.size() > 0) ? q[0] : m_last;
                    2'd1: m_rdata = {5'b0, m_ov, m_stop, q.size() > 0};
                    2'd2: m_rdata = {7'b0, m_ie};
                    default: m_rdata = '0;
                endcase
                if (bus_addr == 2'd0 && q.size() > 0) begin
                    m_last = q.pop_front();
                    popped++;
                end
            end
            if (rx_valid) begin
                if (q.size() < DEPTH) q.push_back(rx_data);
                else drop = 1;
            end
            if (drop) m_ov = 1;
            else if (bus_rd && bus_addr == 2'd1) m_ov = 0;
            if (bus_wr && bus_addr == 2'd2) m_ie = bus_wdata[0];
            if (q.size() >= HI) m_stop = 1;
            else if (q.size() <= LO) m_stop = 0;
        end
    end

    // every-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(stop_req == m_stop, "R4/R5 stop_req vs model", stop_req, m_stop);
            check(irq == (m_ie && q.size() > 0), "R10 irq vs model", irq, m_ie && q.size() > 0);
            check(bus_rdata == m_rdata, "R2 bus_rdata vs model", bus_rdata, m_rdata);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("[TB] FAIL watchdog expired actual=%0d expected<%0d", cycles, WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    task automatic drive(input bit v, input logic [7:0] b, input bit rd, input bit wr,
                         input logic [1:0] a, input logic [7:0] wd);
        @(negedge clk);
        rx_valid = v; rx_data = b; bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    endtask

    task automatic idle();
        drive(0, 8'h00, 0, 0, 2'd0, 8'h00);
    endtask

    task automatic push(input logic [7:0] b);
        drive(1, b, 0, 0, 2'd0, 8'h00);
    endtask

    // issue a read, then sample the result one edge later
    task automatic rd_reg(input logic [1:0] a, output logic [7:0] v);
        drive(0, 8'h00, 1, 0, a, 8'h00);
        idle();
        v = bus_rdata;
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle();
        // R1 reset state
        check(stop_req == 0, "R1 stop_req after reset", stop_req, 0);
        check(irq == 0, "R1 irq after reset", irq, 0);
        check(bus_rdata == 0, "R1 bus_rdata after reset", bus_rdata, 0);
        rd_reg(2'd1, v);
        check(v == 8'h00, "R1 status after reset", v, 8'h00);
        // R9 empty read after reset
        rd_reg(2'd0, v);
        check(v == 8'h00, "R9 empty read after reset", v, 8'h00);

        // R2 ordering
        for (int i = 0; i < 5; i++) push(8'hA0 + 8'(i));
        idle();
        for (int i = 0; i < 5; i++) begin
            rd_reg(2'd0, v);
            check(v == 8'hA0 + 8'(i), "R2 arrival order", v, 8'hA0 + 8'(i));
        end
        // R9 empty read returns last byte
        rd_reg(2'd0, v);
        check(v == 8'hA4, "R9 empty read repeats last", v, 8'hA4);
        rd_reg(2'd1, v);
        check(v == 8'h00, "R9 still empty", v, 8'h00);

        // R4 threshold
        for (int i = 0; i < 11; i++) push(8'h40 + 8'(i));
        idle();
        check(stop_req == 0, "R4 low at 11", stop_req, 0);
        push(8'h4B);
        idle();
        check(stop_req == 1, "R4 high at 12", stop_req, 1);
        for (int i = 12; i < 16; i++) push(8'h40 + 8'(i));
        idle();
        rd_reg(2'd1, v);
        check(v == 8'h03, "R3 sixteen held, no overrun", v, 8'h03);
        // R7 drop when full
        push(8'h50);
        idle();
        rd_reg(2'd1, v);
        check(v == 8'h07, "R7 R8 overrun shown", v, 8'h07);
        rd_reg(2'd1, v);
        check(v == 8'h03, "R8 overrun cleared by read", v, 8'h03);
        // R5 release
        for (int i = 0; i < 7; i++) begin
            rd_reg(2'd0, v);
            if (i == 0) check(v == 8'h40, "R3 oldest kept", v, 8'h40);
        end
        check(stop_req == 1, "R5 still high at 9", stop_req, 1);
        rd_reg(2'd0, v);
        check(stop_req == 0, "R5 low at 8", stop_req, 0);
        for (int i = 0; i < 8; i++) rd_reg(2'd0, v);
        check(v == 8'h4F, "R7 dropped byte not stored", v, 8'h4F);
        rd_reg(2'd0, v);
        check(v == 8'h4F, "R9 empty read after drain", v, 8'h4F);

        // R8 drop and status read in same cycle: set wins
        for (int i = 0; i < 16; i++) push(8'h10 + 8'(i));
        drive(1, 8'hEE, 1, 0, 2'd1, 8'h00);
        idle();
        check(bus_rdata == 8'h03, "R8 status before same-cycle drop", bus_rdata, 8'h03);
        rd_reg(2'd1, v);
        check(v == 8'h07, "R8 drop wins over clear", v, 8'h07);
        rd_reg(2'd1, v);
        // R7 push with simultaneous data read when full
        drive(1, 8'h99, 1, 0, 2'd0, 8'h00);
        idle();
        check(bus_rdata == 8'h10, "R7 read while full", bus_rdata, 8'h10);
        rd_reg(2'd1, v);
        check(v == 8'h03, "R7 simultaneous push accepted", v, 8'h03);
        for (int i = 0; i < 16; i++) rd_reg(2'd0, v);
        check(v == 8'h99, "R7 accepted byte last", v, 8'h99);

        // R10 interrupt
        push(8'h55);
        idle();
        check(irq == 0, "R10 disabled", irq, 0);
        drive(0, 8'h00, 0, 1, 2'd2, 8'h01);
        idle();
        check(irq == 1, "R10 enabled with data", irq, 1);
        rd_reg(2'd2, v);
        check(v == 8'h01, "R10 control readback", v, 8'h01);
        rd_reg(2'd0, v);
        check(irq == 0, "R10 low when empty", irq, 0);

        // R6 sender overshooting by three after stop, slow reader
        begin
            int sent, late;
            bit saw_stop;
            sent = 0; late = 0; saw_stop = 0;
            popped = 0;
            for (int c = 0; c < 2000 && sent < 60; c++) begin
                bit sv, rdn;
                @(negedge clk);
                sv = 0;
                if (stop_req) begin
                    saw_stop = 1;
                    if (late < 3) begin sv = 1; late++; end
                end else begin
                    late = 0; sv = 1;
                end
                rdn = (c % 4 == 3);
                rx_valid = sv; rx_data = 8'(sent);
                bus_rd = rdn; bus_wr = 0; bus_addr = 2'd0;
                if (sv) sent++;
            end
            for (int i = 0; i < 20; i++) drive(0, 8'h00, 1, 0, 2'd0, 8'h00);
            idle();
            check(saw_stop == 1, "R6 stop asserted during stream", saw_stop, 1);
            check(popped == 60, "R6 all characters delivered", popped, 60);
            rd_reg(2'd1, v);
            check(v == 8'h00, "R6 no overrun, empty", v, 8'h00);
        end

        repeat (2) idle();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule